// File: doc/BRIEF.md
# Power-Gated Conversion Sequencer

This block sequences a low-power successive-approximation converter that spends most of its time switched off. A single asynchronous start strobe drives it. The strobe's rising edge wakes the analog section. Its falling edge asks for a conversion. When the conversion ends, the result goes into the output register and the analog section is switched off again. The block times both the wake-up interval and the conversion interval with one cycle counter clocked by the system clock. Both intervals are parameters given in clock cycles.

The strobe may fall before wake-up has finished. In that case the sequencer remembers the request and starts converting on the first cycle after the wake-up count expires, so a conversion never runs on an unpowered front end. The sample-decision logic sits outside this block: a stub input supplies the value that is latched at the end of a conversion. The output register keeps the previous result until a new one replaces it.

Top module: `adcseq_top`

## Requirements
- R1: While reset is held and on the first cycle after it, `powerEn`, `busy` and `resultValid` are 0 and `resultWord` is 0.
- R2: A strobe rise seen while powered off sets `powerEn` and `busy` on the third rising clock edge after the strobe goes high. Two of those edges are synchronizer stages and one is the state register.
- R3: Wake-up lasts exactly `PWRUP_CYCLES` cycles. No conversion starts before that count has expired.
- R4: If the strobe falls after wake-up has finished, the conversion starts on the third clock edge after the fall. The result is latched `CONV_CYCLES` edges after the conversion starts.
- R5: If the strobe falls during wake-up, the request is held and the conversion starts on the edge where wake-up ends.
- R6: On the latching edge, `resultValid` goes high for exactly one cycle and `resultWord` takes the value of `sampleIn`. If the synchronized strobe is low, `powerEn` and `busy` drop on that same edge.
- R7: With an early fall, the time from `powerEn` rising to `resultValid` is `PWRUP_CYCLES + CONV_CYCLES` cycles.
- R8: `resultWord` keeps the previous result until the next latching edge.
- R9: A strobe pulse that rises while a conversion is running neither restarts nor aborts it. The result arrives at the unchanged time, and power drops afterwards.
- R10: If the synchronized strobe is high when a conversion ends, `powerEn` stays 1 and `busy` goes 0. The next strobe fall then starts a new conversion on the third edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strobeIn | input | 1 | Asynchronous conversion-start strobe |
| sampleIn | input | DATA_W | Conversion value from the decision-logic stub |
| powerEn | output | 1 | Analog section power enable |
| busy | output | 1 | High from the start of wake-up until a result is latched |
| resultValid | output | 1 | One-cycle pulse when a new result is latched |
| resultWord | output | DATA_W | Latched conversion result |

## Verification
From the cycle in which the strobe is driven high, `powerEn` is due three edges later. `resultValid` is due at one edge, plus the larger of `PWRUP_CYCLES + 2` and the fall delay plus 2, plus `CONV_CYCLES`. The bench drives every stimulus on a falling clock edge and keeps a count of rising edges. It compares the counted cycle in which each output changes against that formula, sweeping the fall delay across the whole wake-up window and beyond it. All outputs are sampled on falling edges, half a period after the register that drives them has updated.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_WAKE,
    ST_READY,
    ST_CONV
  } seqState_e;

  // synchronized strobe events handed from datapath to control
  typedef struct packed {
    logic rise;
    logic fall;
    logic level;
  } strobeEvt_t;

  // control strobes handed from control to datapath
  typedef struct packed {
    logic latch;
  } dpCtl_t;

endpackage

// File: rtl/adcseq_dpath.sv
module adcseq_dpath
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] sampleIn,
  input  dpCtl_t            ctl,
  output strobeEvt_t        evt,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultWord
);

  logic syncA, syncB, syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= strobeIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign evt.rise  = syncB & ~syncPrev;
  assign evt.fall  = ~syncB & syncPrev;
  assign evt.level = syncB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultWord  <= '0;
    end else begin
      resultValid <= ctl.latch;
      if (ctl.latch) resultWord <= sampleIn;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latch |=> $stable(resultWord));

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int PWRUP_CYCLES = 75,
  parameter int CONV_CYCLES  = 115
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeEvt_t evt,
  output dpCtl_t     ctl,
  output logic       powerEn,
  output logic       busy
);

  localparam int MAX_CYC = (PWRUP_CYCLES > CONV_CYCLES) ? PWRUP_CYCLES : CONV_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(PWRUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

  seqState_e        state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic             pendFall, pendNx;
  logic             spent, spentNx;
  logic             wakeDone, convDone;

  assign wakeDone = (state == ST_WAKE) && (cnt == WAKE_LAST);
  assign convDone = (state == ST_CONV) && (cnt == CONV_LAST);

  always_comb begin
    stateNx = state;
    cntNx   = cnt + 1'b1;
    pendNx  = pendFall;
    spentNx = spent;
    unique case (state)
      ST_OFF: begin
        cntNx  = '0;
        pendNx = 1'b0;
        if (evt.rise) begin
          stateNx = ST_WAKE;
          spentNx = 1'b0;
        end
      end
      ST_WAKE: begin
        if (evt.fall) pendNx = 1'b1;
        if (wakeDone) begin
          cntNx  = '0;
          pendNx = 1'b0;
          stateNx = (pendFall || evt.fall) ? ST_CONV : ST_READY;
        end
      end
      ST_READY: begin
        cntNx = '0;
        if (evt.fall) begin
          stateNx = ST_CONV;
          spentNx = 1'b0;
        end
      end
      ST_CONV: begin
        if (convDone) begin
          cntNx   = '0;
          stateNx = evt.level ? ST_READY : ST_OFF;
          spentNx = evt.level;
        end
      end
      default: stateNx = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OFF;
      cnt      <= '0;
      pendFall <= 1'b0;
      spent    <= 1'b0;
    end else begin
      state    <= stateNx;
      cnt      <= cntNx;
      pendFall <= pendNx;
      spent    <= spentNx;
    end
  end

  assign ctl.latch = convDone;
  assign powerEn   = (state != ST_OFF);
  assign busy      = (state != ST_OFF) && !((state == ST_READY) && spent);

  // R3
  wake_before_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && $past(state) == ST_WAKE) |-> $past(cnt) == WAKE_LAST);

  // R2
  off_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && !evt.rise) |=> !powerEn);

  // R6
  power_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latch && !evt.level) |=> (!powerEn && !busy));

  // R10
  stay_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latch && evt.level) |=> (powerEn && !busy));

  // R9
  conv_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && evt.rise && !ctl.latch) |=> (state == ST_CONV && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int PWRUP_CYCLES = 75,
  parameter int CONV_CYCLES  = 115,
  parameter int DATA_W       = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeIn,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              powerEn,
  output logic              busy,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultWord
);

  strobeEvt_t evt;
  dpCtl_t     ctl;

  adcseq_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobeIn    (strobeIn),
    .sampleIn    (sampleIn),
    .ctl         (ctl),
    .evt         (evt),
    .resultValid (resultValid),
    .resultWord  (resultWord)
  );

  adcseq_ctrl #(.PWRUP_CYCLES(PWRUP_CYCLES), .CONV_CYCLES(CONV_CYCLES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .ctl     (ctl),
    .powerEn (powerEn),
    .busy    (busy)
  );

endmodule

// File: tb/adcseq_top_tb_top.sv
`timescale 1ns/1ps
module adcseq_top_tb_top;

  localparam int P  = 4;
  localparam int C  = 6;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          strobeIn = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          powerEn, busy, resultValid;
  logic [DW-1:0] resultWord;

  int cyc = 0;
  int nChk = 0;
  int nFail = 0;
  logic [DW-1:0] prevWord = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adcseq_top #(.PWRUP_CYCLES(P), .CONV_CYCLES(C), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .sampleIn(sampleIn),
    .powerEn(powerEn), .busy(busy), .resultValid(resultValid), .resultWord(resultWord)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one conversion: strobe high for d cycles, optional pulse during conversion
  task automatic runConv(int d, logic [DW-1:0] val, bit midPulse);
    int n, expPwr, expValid, gotPwr, gotValid, convRel;
    gotPwr = -1;
    gotValid = -1;
    @(negedge clk);
    sampleIn = val;
    strobeIn = 1'b1;
    n = cyc;
    expPwr = n + 3;
    expValid = n + 1 + ((P + 2 > d + 2) ? P + 2 : d + 2) + C;
    convRel = expValid - C - n;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == d) strobeIn = 1'b0;
      if (midPulse && i == convRel) strobeIn = 1'b1;
      if (midPulse && i == convRel + 1) strobeIn = 1'b0;
      if (powerEn && gotPwr < 0) gotPwr = cyc;
      if (i == 3) chk(resultWord == prevWord, "R8 old word held", resultWord, prevWord);
      if (resultValid && gotValid < 0) begin
        gotValid = cyc;
        chk(resultWord == val, "R6 latched word", resultWord, val);
        chk(!powerEn && !busy, "R6 power down at latch", {powerEn, busy}, 0);
      end else if (gotValid >= 0 && cyc == gotValid + 1) begin
        chk(!resultValid, "R6 single-cycle valid", resultValid, 0);
      end
    end
    chk(gotPwr == expPwr, "R2 power-up edge", gotPwr, expPwr);
    if (midPulse) chk(gotValid == expValid, "R9 mid-conversion rise ignored", gotValid, expValid);
    else if (d <= P) chk(gotValid == expValid, "R5 early fall held", gotValid, expValid);
    else chk(gotValid == expValid, "R4 late fall conversion", gotValid, expValid);
    if (d <= P && !midPulse)
      chk(gotValid - gotPwr == P + C, "R7 effective time", gotValid - gotPwr, P + C);
    chk(!powerEn && !busy, "R3 idle after run", {powerEn, busy}, 0);
    prevWord = val;
  endtask

  // strobe held high across conversion end, then a later fall
  task automatic runHold(logic [DW-1:0] v1, logic [DW-1:0] v2);
    int n, expV1, expV2, fallI;
    @(negedge clk);
    sampleIn = v1;
    strobeIn = 1'b1;
    n = cyc;
    expV1 = n + 1 + P + 2 + C;
    fallI = P + C + 8;
    expV2 = n + fallI + 1 + 2 + C;
    for (int i = 1; i <= fallI + C + 10; i++) begin
      @(negedge clk);
      if (i == 1) strobeIn = 1'b0;
      if (i == P + 3) strobeIn = 1'b1;
      if (i == fallI) begin
        strobeIn = 1'b0;
        sampleIn = v2;
      end
      if (cyc == expV1) begin
        chk(resultValid && resultWord == v1, "R10 first result", resultWord, v1);
        chk(powerEn && !busy, "R10 stays powered, not busy", {powerEn, busy}, 2);
      end
      if (cyc == expV1 + 4) chk(powerEn && !busy, "R10 powered wait", {powerEn, busy}, 2);
      if (cyc == expV2 - 1) chk(busy && !resultValid, "R10 second conversion running", {busy, resultValid}, 2);
      if (cyc == expV2) begin
        chk(resultValid && resultWord == v2, "R10 second result", resultWord, v2);
        chk(!powerEn, "R10 power down after second", powerEn, 0);
      end
    end
    prevWord = v2;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!powerEn && !busy && !resultValid && resultWord == 0, "R1 reset state",
        {powerEn, busy, resultValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!powerEn && !busy && !resultValid && resultWord == 0, "R1 after reset",
        {powerEn, busy, resultValid}, 0);
    for (int d = 1; d <= P + 4; d++)
      runConv(d, DW'((d * 97 + 13) % 1024), 1'b0);
    runConv(2, 10'h3ff, 1'b1);
    runConv(P + 3, 10'h155, 1'b1);
    runHold(10'h2aa, 10'h001);
    runConv(P, 10'h000, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule